// File: doc/BRIEF.md
# Real-Time Clock Serial Register Interface

This block is the target-side transaction handler of a real-time clock on a two-wire serial bus. A separate bit-level engine turns line activity into byte-level events, one per cycle at most: start, repeated start, stop, address byte (7-bit device address plus a read/write flag), write-data byte and read-data request. The block decodes these events, acknowledges its own device address, and reads or writes a 64-byte register space through an auto-incrementing pointer.

Location 7 is a control register whose output-level, square-wave-enable and rate-select fields drive output pins. The other 63 locations (the timekeeping bytes 0 to 6 and the 56 general-purpose bytes 8 to 0x3F) sit in a single memory that maps onto block RAM. Time counting and line-level signalling are handled by the engine and the time counter outside this block.

A host writes by sending an address byte with the write flag. The first data byte then sets the pointer and each further byte is stored at the pointer. To read, the host sets the pointer the same way, issues a repeated start and the address byte with the read flag, and requests bytes until it sends a stop.

Top module: `rtc_bus_regfile`

## Requirements
- R1: Synchronous reset clears the pointer to 0, the control register to 0x00, `ack_o` and `rd_valid_o`. Memory contents are not altered by reset.
- R2: Event kinds on `ev_kind_i` are 0 start, 1 repeated start, 2 stop, 3 address byte, 4 write data, 5 read request. An address byte is taken only as the first event after a start or repeated start. Its bits 7:1 are the device address and bit 0 is 1 for read. Only address 0x68 raises `ack_o` for one cycle after the event. Any other address makes the block ignore every data and read event until the next start or repeated start.
- R3: The first write-data byte after a matching write address loads the pointer from its bits 5:0.
- R4: Each further write-data byte is stored at the pointer, and the pointer then advances by one.
- R5: After a matching read address, each read request returns the byte at the pointer on `rd_data_o`, with `rd_valid_o` high for one cycle after the request, and the pointer then advances by one.
- R6: The pointer wraps from 0x3F to 0x00 on both writes and reads.
- R7: A write to location 7 keeps bits 7, 4 and 1:0 and clears bits 6, 5, 3 and 2. Bit 7 drives `out_level_o`, bit 4 drives `sqw_en_o` and bits 1:0 drive `sqw_rate_o`. A read of location 7 returns the stored value, so the reserved bits read as 0.
- R8: A read that follows no pointer write in its transaction starts at the pointer left by the last access. After reset this is location 0.
- R9: Write-data and read events outside an addressed transaction (after a stop, or before any start) change neither the memory nor the pointer, and raise no `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | A bus event is presented this cycle |
| ev_kind_i | input | 3 | Event kind (encoding in R2) |
| ev_byte_i | input | 8 | Address or write-data byte carried by the event |
| ack_o | output | 1 | One-cycle acknowledge of a matching address byte |
| rd_valid_o | output | 1 | One-cycle strobe: `rd_data_o` carries a read byte |
| rd_data_o | output | 8 | Byte returned for a read request |
| out_level_o | output | 1 | Control register output-level bit |
| sqw_en_o | output | 1 | Control register square-wave enable |
| sqw_rate_o | output | 2 | Control register square-wave rate select |

## Verification
The assertions assume the bit engine presents at most one event per cycle, with a defined kind and byte whenever `ev_valid_i` is high. They also assume read requests arrive only after the engine has seen a read address phase. The bench keeps to this by driving each event for exactly one cycle and following it with an idle cycle. It uses only the six defined kind codes and reads only locations it has already written.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RESTART = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR    = 3'd3,
    EV_WDATA   = 3'd4,
    EV_RDATA   = 3'd5
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_PTR   = 3'd2,
    ST_WRITE = 3'd3,
    ST_READ  = 3'd4
  } txn_state_e;

  // control register field positions
  localparam int CTL_LEVEL_BIT = 7;
  localparam int CTL_SQWE_BIT  = 4;
  localparam int CTL_RATE_LSB  = 0;
  localparam int CTL_RATE_W    = 2;

endpackage

// File: rtl/rtc_txn_fsm.sv
module rtc_txn_fsm
  import rtc_bus_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          BYTE_W   = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid_i,
  input  logic [2:0]        ev_kind_i,
  input  logic [BYTE_W-1:0] ev_byte_i,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [2:0]        state_o
);

  txn_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              ack_q;
  logic              addr_hit;
  logic              is_wdata;
  logic              is_rdata;

  always_comb begin
    addr_hit = (ev_byte_i[7:1] == DEV_ADDR);
    is_wdata = ev_valid_i && (ev_kind_i == EV_WDATA);
    is_rdata = ev_valid_i && (ev_kind_i == EV_RDATA);
    wr_en_o  = is_wdata && (state_q == ST_WRITE);
    rd_en_o  = is_rdata && (state_q == ST_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (ev_valid_i) begin
        case (ev_kind_e'(ev_kind_i))
          EV_START, EV_RESTART: state_q <= ST_ADDR;
          EV_STOP:              state_q <= ST_IDLE;
          EV_ADDR: begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                ack_q   <= 1'b1;
                state_q <= ev_byte_i[0] ? ST_READ : ST_PTR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          EV_WDATA: begin
            if (state_q == ST_PTR) begin
              ptr_q   <= ev_byte_i[ADDR_W-1:0];
              state_q <= ST_WRITE;
            end else if (state_q == ST_WRITE) begin
              ptr_q <= ptr_q + ADDR_W'(1);
            end
          end
          EV_RDATA: begin
            if (state_q == ST_READ) ptr_q <= ptr_q + ADDR_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_o   = ack_q;
  assign ptr_o   = ptr_q;
  assign state_o = state_q;

endmodule

// File: rtl/rtc_store_ram.sv
module rtc_store_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) q <= mem[raddr_i];
  end

  assign rdata_o = q;

endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int               DATA_W    = 8,
  parameter logic [DATA_W-1:0] KEEP_MASK = 8'h93
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (we_i) q <= wdata_i & KEEP_MASK;
  end

  assign q_o = q;

endmodule

// File: rtl/rtc_bus_regfile.sv
module rtc_bus_regfile
  import rtc_bus_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         BYTE_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         CTL_LOC  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid_i,
  input  logic [2:0]        ev_kind_i,
  input  logic [BYTE_W-1:0] ev_byte_i,
  output logic              ack_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              out_level_o,
  output logic              sqw_en_o,
  output logic [1:0]        sqw_rate_o
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CTL_LOC);
  localparam logic [BYTE_W-1:0] CTL_KEEP =
      BYTE_W'((1 << CTL_LEVEL_BIT) | (1 << CTL_SQWE_BIT) |
              (((1 << CTL_RATE_W) - 1) << CTL_RATE_LSB));

  logic              wr_en;
  logic              rd_en;
  logic [ADDR_W-1:0] ptr_q;
  logic [2:0]        state_q;
  logic [BYTE_W-1:0] ram_q;
  logic [BYTE_W-1:0] ctl_q;
  logic              at_ctl;
  logic              rd_valid_q;
  logic              sel_ctl_q;

  rtc_txn_fsm #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ev_valid_i(ev_valid_i),
    .ev_kind_i (ev_kind_i),
    .ev_byte_i (ev_byte_i),
    .ack_o     (ack_o),
    .wr_en_o   (wr_en),
    .rd_en_o   (rd_en),
    .ptr_o     (ptr_q),
    .state_o   (state_q)
  );

  assign at_ctl = (ptr_q == CTL_ADDR);

  rtc_store_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(BYTE_W)
  ) u_ram (
    .clk    (clk),
    .we_i   (wr_en && !at_ctl),
    .waddr_i(ptr_q),
    .wdata_i(ev_byte_i),
    .re_i   (rd_en),
    .raddr_i(ptr_q),
    .rdata_o(ram_q)
  );

  rtc_ctrl_reg #(
    .DATA_W   (BYTE_W),
    .KEEP_MASK(CTL_KEEP)
  ) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .we_i   (wr_en && at_ctl),
    .wdata_i(ev_byte_i),
    .q_o    (ctl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      sel_ctl_q  <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) sel_ctl_q <= at_ctl;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = sel_ctl_q ? ctl_q : ram_q;
  assign out_level_o = ctl_q[CTL_LEVEL_BIT];
  assign sqw_en_o    = ctl_q[CTL_SQWE_BIT];
  assign sqw_rate_o  = ctl_q[CTL_RATE_LSB +: CTL_RATE_W];

endmodule

// File: rtl/rtc_bus_regfile_chk.sv
module rtc_bus_regfile_chk
  import rtc_bus_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [2:0]        ev_kind,
  input logic [7:0]        ev_byte,
  input logic              ack,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] ptr,
  input logic [2:0]        state
);

  localparam logic [ADDR_W-1:0] PTR_TOP = '1;

  logic wr_step;
  logic rd_step;
  assign wr_step = ev_valid && (ev_kind == EV_WDATA) && (state == ST_WRITE);
  assign rd_step = ev_valid && (ev_kind == EV_RDATA) && (state == ST_READ);

  assert_ack_match_R2: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(ev_valid && (ev_kind == EV_ADDR) && (ev_byte[7:1] == DEV_ADDR)));

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && (ev_kind == EV_WDATA) && (state == ST_PTR))
      |=> (ptr == $past(ev_byte[ADDR_W-1:0])));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    wr_step |=> (ptr == ADDR_W'($past(ptr) + 1)));

  assert_rd_follows_req_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(ev_valid && (ev_kind == EV_RDATA)));

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    ((wr_step || rd_step) && (ptr == PTR_TOP)) |=> (ptr == '0));

  assert_ctl_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ($past(ptr) == ADDR_W'(7))) |-> ((rd_data & 8'h6C) == 8'h00));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && ev_valid && ((ev_kind == EV_WDATA) || (ev_kind == EV_RDATA)))
      |=> ($stable(ptr) && !rd_valid));

endmodule

bind rtc_bus_regfile rtc_bus_regfile_chk #(
  .ADDR_W  (ADDR_W),
  .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ev_valid(ev_valid_i),
  .ev_kind (ev_kind_i),
  .ev_byte (ev_byte_i),
  .ack     (ack_o),
  .rd_valid(rd_valid_o),
  .rd_data (rd_data_o),
  .ptr     (ptr_q),
  .state   (state_q)
);

// File: tb/rtc_bus_regfile_tb.sv
module rtc_bus_regfile_tb;

  localparam logic [2:0] KS = 3'd0, KR = 3'd1, KP = 3'd2,
                         KA = 3'd3, KW = 3'd4, KD = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  data;
    logic        ack;
    logic        rdv;
    logic [7:0]  rd;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 57;
  localparam vec_t VEC [NV] = '{
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R2"},
    '{KW, 8'h10, 1'b0, 1'b0, 8'h00, "R3"},
    '{KW, 8'hA5, 1'b0, 1'b0, 8'h00, "R4"},
    '{KW, 8'h3C, 1'b0, 1'b0, 8'h00, "R4"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R4"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R5"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R5"},
    '{KW, 8'h10, 1'b0, 1'b0, 8'h00, "R3"},
    '{KR, 8'h00, 1'b0, 1'b0, 8'h00, "R5"},
    '{KA, 8'hD1, 1'b1, 1'b0, 8'h00, "R5"},
    '{KD, 8'h00, 1'b0, 1'b1, 8'hA5, "R5"},
    '{KD, 8'h00, 1'b0, 1'b1, 8'h3C, "R5"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R5"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R7"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R7"},
    '{KW, 8'h07, 1'b0, 1'b0, 8'h00, "R7"},
    '{KW, 8'hFF, 1'b0, 1'b0, 8'h00, "R7"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R7"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R7"},
    '{KW, 8'h07, 1'b0, 1'b0, 8'h00, "R7"},
    '{KR, 8'h00, 1'b0, 1'b0, 8'h00, "R7"},
    '{KA, 8'hD1, 1'b1, 1'b0, 8'h00, "R7"},
    '{KD, 8'h00, 1'b0, 1'b1, 8'h93, "R7"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R7"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KA, 8'hA0, 1'b0, 1'b0, 8'h00, "R2"},
    '{KW, 8'h10, 1'b0, 1'b0, 8'h00, "R2"},
    '{KW, 8'h55, 1'b0, 1'b0, 8'h00, "R2"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R6"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R6"},
    '{KW, 8'h3F, 1'b0, 1'b0, 8'h00, "R6"},
    '{KW, 8'h11, 1'b0, 1'b0, 8'h00, "R6"},
    '{KW, 8'h22, 1'b0, 1'b0, 8'h00, "R6"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R6"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R8"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R8"},
    '{KW, 8'h3F, 1'b0, 1'b0, 8'h00, "R8"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R8"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R8"},
    '{KA, 8'hD1, 1'b1, 1'b0, 8'h00, "R8"},
    '{KD, 8'h00, 1'b0, 1'b1, 8'h11, "R8"},
    '{KD, 8'h00, 1'b0, 1'b1, 8'h22, "R6"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R8"},
    '{KD, 8'h00, 1'b0, 1'b0, 8'h00, "R9"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KA, 8'hD0, 1'b1, 1'b0, 8'h00, "R2"},
    '{KW, 8'h10, 1'b0, 1'b0, 8'h00, "R2"},
    '{KR, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KA, 8'hD1, 1'b1, 1'b0, 8'h00, "R2"},
    '{KD, 8'h00, 1'b0, 1'b1, 8'hA5, "R2"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KS, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KA, 8'hA1, 1'b0, 1'b0, 8'h00, "R2"},
    '{KD, 8'h00, 1'b0, 1'b0, 8'h00, "R2"},
    '{KP, 8'h00, 1'b0, 1'b0, 8'h00, "R2"}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'h00;
  logic       ack, rd_valid, out_level, sqw_en;
  logic [7:0] rd_data;
  logic [1:0] sqw_rate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_bus_regfile u_dut (
    .clk        (clk),
    .rst        (rst),
    .ev_valid_i (ev_valid),
    .ev_kind_i  (ev_kind),
    .ev_byte_i  (ev_byte),
    .ack_o      (ack),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .out_level_o(out_level),
    .sqw_en_o   (sqw_en),
    .sqw_rate_o (sqw_rate)
  );

  task automatic chk(input logic [15:0] tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one event for one cycle; outputs are sampled on the following falling edge
  task automatic send(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = k;
    ev_byte  = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "ack", {7'd0, ack}, 8'h00);
    chk("R1", "rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R1", "ctrl", {out_level, 2'b00, sqw_en, 2'b00, sqw_rate}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].kind, VEC[i].data);
      chk(VEC[i].tag, "ack", {7'd0, ack}, {7'd0, VEC[i].ack});
      chk(VEC[i].tag, "rd_valid", {7'd0, rd_valid}, {7'd0, VEC[i].rdv});
      if (VEC[i].rdv) chk(VEC[i].tag, "rd_data", rd_data, VEC[i].rd);
    end

    // R7: control fields at the pins after writing 0xFF to location 7
    chk("R7", "out_level", {7'd0, out_level}, 8'h01);
    chk("R7", "sqw_en", {7'd0, sqw_en}, 8'h01);
    chk("R7", "sqw_rate", {6'd0, sqw_rate}, 8'h03);

    // R1: reset mid-run clears control and pointer, keeps memory
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "ctrl after reset", {out_level, 2'b00, sqw_en, 2'b00, sqw_rate}, 8'h00);
    chk("R1", "rd_valid after reset", {7'd0, rd_valid}, 8'h00);
    send(KS, 8'h00);
    send(KA, 8'hD1);
    chk("R8", "ack read addr", {7'd0, ack}, 8'h01);
    send(KD, 8'h00);
    chk("R1", "read at pointer 0 valid", {7'd0, rd_valid}, 8'h01);
    chk("R1", "read at pointer 0 data", rd_data, 8'h22);
    send(KP, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule